// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Pending Controller

This block holds the per-vector message table and the pending-bit array of an endpoint that signals interrupts by memory writes. Software programs each vector's 64-bit target address, 32-bit payload and mask bit through a 32-bit register port. The port has two windows: the vector table and the read-only pending array. The enclosing configuration logic drives the capability enable and the function-wide mask into the block. The device core marks which vectors it uses and raises requests by vector index.

A request on an unmasked vector that is in use becomes an outgoing message write on a valid/ready port. A request on a masked vector sets its pending bit instead. As soon as that vector becomes unmasked, the pending bit is cleared and the message is sent. The vector can become unmasked by a table write, by setting the enable or by releasing the function mask. When several vectors are deliverable together, they leave in ascending index order, one per accepted handshake.

Top module: `msix_vector_ctrl`

## Requirements
- R1: The table window address is vector*16 + word*4. Word 0 holds address bits 31:0, word 1 holds address bits 63:32 and word 2 holds the data. Word 3 is the control word: only bit 0, the vector mask, is stored, and the other bits read 0. Only the upper address bits above bit 1 decode.
- R2: After reset, every table address and data word reads 0, every control word reads 1, all pending bits read 0 and no message is valid.
- R3: A vector is masked when its control bit 0 is set, when the enable input is 0, or when the function-mask input is 1.
- R4: A request on an in-use, unmasked vector produces one message carrying that entry's address, data and vector index.
- R5: A request on a vector whose in-use flag is 0, or whose index is NUM_VEC or more, is dropped: no message and no pending bit.
- R6: A request on a masked, in-use vector sets its pending bit and sends nothing. The pending array is read as 32-bit little-endian words, with vector v at bit v%32 of word v/32. The array spans NUM_VEC rounded up to a multiple of 64 bits, and the unimplemented bits read 0.
- R7: When a pending vector becomes unmasked, for any reason, its pending bit clears and its message is sent.
- R8: Vectors that are deliverable at the same time are sent in ascending index order.
- R9: Writes to the pending window have no effect.
- R10: Clearing a vector's in-use flag clears its pending bit, so it does not signal when it is later unmasked.
- R11: A valid message keeps its address, data and index unchanged until ready is sampled high, even across table writes to that vector.
- R12: The size output reports NUM_VEC-1. NUM_VEC must lie in 1..2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msix_en_i | input | 1 | Capability enable from configuration logic |
| func_mask_i | input | 1 | Function-wide mask from configuration logic |
| vec_used_i | input | NUM_VEC | Per-vector in-use flags from the device core |
| irq_valid_i | input | 1 | Interrupt request strobe |
| irq_vec_i | input | VW | Requested vector index |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_win_i | input | 1 | 0 = vector table, 1 = pending array |
| reg_addr_i | input | AW | Byte address within the window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| tbl_size_o | output | 11 | Vector count minus one |
| msg_valid_o | output | 1 | Message write valid |
| msg_ready_i | input | 1 | Message write accepted |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |
| msg_vec_o | output | VW | Index of the vector being sent |

## Verification
The bench builds the block with 16 vectors, so the index is 5 bits wide. Index 20 is then a legal out-of-range input, and the pending array spans two words, of which the second is entirely unimplemented. That size allows every reset word of every entry to be read, a request to be sent on each vector, and a function-mask release that delivers all 16 vectors back to back, so the ascending order can be observed across the whole table.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int ENTRY_BYTES = 16;
  localparam int MAX_VEC     = 2048;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } entry_word_e;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VW      = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [VW-1:0]      wr_vec_i,
  input  entry_word_e        wr_word_i,
  input  logic [31:0]        wr_data_i,
  input  logic [VW-1:0]      rd_vec_i,
  input  entry_word_e        rd_word_i,
  output logic [31:0]        rd_data_o,
  input  logic [VW-1:0]      sel_vec_i,
  output logic [63:0]        sel_addr_o,
  output logic [31:0]        sel_data_o,
  output logic [NUM_VEC-1:0] mask_o
);
  logic [31:0] lo_q  [NUM_VEC];
  logic [31:0] hi_q  [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        lo_q[v]  <= '0;
        hi_q[v]  <= '0;
        dat_q[v] <= '0;
      end
      mask_q <= '1;  // entries zeroed, then all masked
    end else if (wr_en_i) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (wr_vec_i == VW'(v)) begin
          unique case (wr_word_i)
            W_ADDR_LO: lo_q[v]  <= wr_data_i;
            W_ADDR_HI: hi_q[v]  <= wr_data_i;
            W_DATA:    dat_q[v] <= wr_data_i;
            W_CTRL:    mask_q[v] <= wr_data_i[0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data_o  = '0;
    sel_addr_o = '0;
    sel_data_o = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (rd_vec_i == VW'(v)) begin
        unique case (rd_word_i)
          W_ADDR_LO: rd_data_o = lo_q[v];
          W_ADDR_HI: rd_data_o = hi_q[v];
          W_DATA:    rd_data_o = dat_q[v];
          W_CTRL:    rd_data_o = {31'b0, mask_q[v]};
        endcase
      end
      if (sel_vec_i == VW'(v)) begin
        sel_addr_o = {hi_q[v], lo_q[v]};
        sel_data_o = dat_q[v];
      end
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/msix_pend_ctrl.sv
module msix_pend_ctrl #(
  parameter int NUM_VEC = 16,
  parameter int VW      = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_valid_i,
  input  logic [VW-1:0]      irq_vec_i,
  input  logic [NUM_VEC-1:0] used_i,
  input  logic [NUM_VEC-1:0] masked_i,
  output logic [VW-1:0]      sel_vec_o,
  input  logic [63:0]        sel_addr_i,
  input  logic [31:0]        sel_data_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [VW-1:0]      msg_vec_o
);
  logic [NUM_VEC-1:0] pend_q, send_q, hit, take, live;
  logic [VW-1:0] pick;
  logic pick_vld, fire;

  assign live = send_q & ~masked_i & used_i;

  // lowest live index wins
  always_comb begin
    pick_vld = 1'b0;
    pick     = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (live[v]) begin
        pick_vld = 1'b1;
        pick     = VW'(v);
      end
    end
  end

  assign fire = pick_vld && (!msg_valid_o || msg_ready_i);

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      hit[v]  = irq_valid_i && (irq_vec_i == VW'(v));
      take[v] = fire && (pick == VW'(v));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      send_q <= '0;
    end else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (!used_i[v]) begin
          pend_q[v] <= 1'b0;
          send_q[v] <= 1'b0;
        end else if (masked_i[v]) begin
          pend_q[v] <= pend_q[v] | send_q[v] | hit[v];
          send_q[v] <= 1'b0;
        end else begin
          pend_q[v] <= 1'b0;
          send_q[v] <= (send_q[v] & ~take[v]) | pend_q[v] | hit[v];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
      msg_vec_o   <= '0;
    end else if (fire) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= sel_addr_i;
      msg_data_o  <= sel_data_i;
      msg_vec_o   <= pick;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  assign sel_vec_o = pick;
  assign pend_o    = pend_q;
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VW      = $clog2(NUM_VEC) + 1,
  parameter int AW      = VW + 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msix_en_i,
  input  logic               func_mask_i,
  input  logic [NUM_VEC-1:0] vec_used_i,
  input  logic               irq_valid_i,
  input  logic [VW-1:0]      irq_vec_i,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic               reg_win_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [10:0]        tbl_size_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [VW-1:0]      msg_vec_o
);
  localparam int PBA_BITS  = ((NUM_VEC + 63) / 64) * 64;
  localparam int PBA_WORDS = PBA_BITS / 32;

  if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_size
    $error("NUM_VEC out of range");
  end

  logic               func_masked;
  logic [NUM_VEC-1:0] ent_mask, masked, pend;
  logic [VW-1:0]      sel_vec;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data, tbl_word, pba_word;
  logic [PBA_BITS-1:0] pba_img;
  logic [VW-1:0]      acc_vec;
  entry_word_e        acc_word;
  logic               unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr_i[1:0];
  assign func_masked = !msix_en_i || func_mask_i;
  assign masked      = ent_mask | {NUM_VEC{func_masked}};
  assign acc_vec     = reg_addr_i[AW-1:4];
  assign acc_word    = entry_word_e'(reg_addr_i[3:2]);
  assign tbl_size_o  = 11'(NUM_VEC - 1);

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VW(VW)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_req_i && reg_we_i && !reg_win_i),
    .wr_vec_i  (acc_vec),
    .wr_word_i (acc_word),
    .wr_data_i (reg_wdata_i),
    .rd_vec_i  (acc_vec),
    .rd_word_i (acc_word),
    .rd_data_o (tbl_word),
    .sel_vec_i (sel_vec),
    .sel_addr_o(sel_addr),
    .sel_data_o(sel_data),
    .mask_o    (ent_mask)
  );

  msix_pend_ctrl #(.NUM_VEC(NUM_VEC), .VW(VW)) i_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_valid_i(irq_valid_i),
    .irq_vec_i  (irq_vec_i),
    .used_i     (vec_used_i),
    .masked_i   (masked),
    .sel_vec_o  (sel_vec),
    .sel_addr_i (sel_addr),
    .sel_data_i (sel_data),
    .pend_o     (pend),
    .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i),
    .msg_addr_o (msg_addr_o),
    .msg_data_o (msg_data_o),
    .msg_vec_o  (msg_vec_o)
  );

  assign pba_img = PBA_BITS'(pend);

  always_comb begin
    pba_word = '0;
    for (int w = 0; w < PBA_WORDS; w++) begin
      if (reg_addr_i[AW-1:2] == (AW-2)'(w)) pba_word = pba_img[w*32 +: 32];
    end
  end

  // pending window is read-only: writes never reach storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      reg_rdata_o <= '0;
    else if (reg_req_i && !reg_we_i)  reg_rdata_o <= reg_win_i ? pba_word : tbl_word;
  end
endmodule

// File: rtl/msix_vector_ctrl_chk.sv
module msix_vector_ctrl_chk #(
  parameter int NUM_VEC = 16,
  parameter int VW      = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msix_en_i,
  input logic               func_mask_i,
  input logic [NUM_VEC-1:0] vec_used_i,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [63:0]        msg_addr_o,
  input logic [31:0]        msg_data_o,
  input logic [VW-1:0]      msg_vec_o
);
  // R11
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o)
      && $stable(msg_data_o) && $stable(msg_vec_o));

  // R5
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> int'(msg_vec_o) < NUM_VEC);

  // R5
  used_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(vec_used_i[msg_vec_o]));

  // R3
  func_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(msix_en_i && !func_mask_i));
endmodule

bind msix_vector_ctrl msix_vector_ctrl_chk #(.NUM_VEC(NUM_VEC), .VW(VW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .msix_en_i  (msix_en_i),
  .func_mask_i(func_mask_i),
  .vec_used_i (vec_used_i),
  .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i),
  .msg_addr_o (msg_addr_o),
  .msg_data_o (msg_data_o),
  .msg_vec_o  (msg_vec_o)
);

// File: tb/test_msix_vector_ctrl.sv
`timescale 1ns/1ps
module test_msix_vector_ctrl;
  localparam int N  = 16;
  localparam int VW = $clog2(N) + 1;
  localparam int AW = VW + 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, fmask = 0;
  logic [N-1:0] used = '0;
  logic irq_v = 0;
  logic [VW-1:0] irq_vec = '0;
  logic req = 0, we = 0, win = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [10:0] tsize;
  logic mvalid, mready = 1;
  logic [63:0] maddr;
  logic [31:0] mdata;
  logic [VW-1:0] mvec;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  msix_vector_ctrl #(.NUM_VEC(N)) i_msix_vector_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .msix_en_i(en), .func_mask_i(fmask),
    .vec_used_i(used), .irq_valid_i(irq_v), .irq_vec_i(irq_vec),
    .reg_req_i(req), .reg_we_i(we), .reg_win_i(win), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tbl_size_o(tsize),
    .msg_valid_o(mvalid), .msg_ready_i(mready), .msg_addr_o(maddr),
    .msg_data_o(mdata), .msg_vec_o(mvec));

  function automatic logic [63:0] exp_addr(int v);
    return {32'h0000_1000 + 32'(v), 32'hFEE0_0000 + 32'(v * 16)};
  endfunction
  function automatic logic [31:0] exp_data(int v);
    return 32'hD000_0000 + 32'(v);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(input logic w, input int a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; win = w; addr = AW'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic reg_rd(input logic w, input int a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; win = w; addr = AW'(a);
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic irq(input int v);
    @(negedge clk); irq_v = 1; irq_vec = VW'(v);
    @(negedge clk); irq_v = 0;
  endtask

  task automatic wait_msg(output bit got, output int v, output logic [63:0] a, output logic [31:0] d);
    got = 0; v = -1; a = '0; d = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (mvalid) begin got = 1; v = int'(mvec); a = maddr; d = mdata; end
    end
  endtask

  task automatic expect_msg(input int v, input string r);
    bit got; int gv; logic [63:0] ga; logic [31:0] gd;
    wait_msg(got, gv, ga, gd);
    chk(got && gv == v, r, 64'(gv), 64'(v));
    chk(ga == exp_addr(v) && gd == exp_data(v), r, {ga[31:0], gd}, {exp_addr(v)[31:0], exp_data(v)});
  endtask

  task automatic expect_none(input string r);
    bit seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mvalid) seen = 1;
    end
    chk(!seen, r, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset values, R12 size field
    chk(!mvalid, "R2", 64'(mvalid), 64'd0);
    chk(tsize == 11'(N - 1), "R12", 64'(tsize), 64'(N - 1));
    for (int v = 0; v < N; v++)
      for (int w = 0; w < 4; w++) begin
        reg_rd(0, v * 16 + w * 4, d);
        chk(d == ((w == 3) ? 32'd1 : 32'd0), "R2", 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
    for (int w = 0; w < 2; w++) begin
      reg_rd(1, w * 4, d);
      chk(d == 0, "R2", 64'(d), 64'd0);
    end

    // R1 control word keeps only bit 0
    reg_wr(0, 12, 32'hFFFF_FFFE);
    reg_rd(0, 12, d);
    chk(d == 0, "R1", 64'(d), 64'd0);
    reg_wr(0, 12, 32'h8000_0001);
    reg_rd(0, 12, d);
    chk(d == 1, "R1", 64'(d), 64'd1);

    // program all entries, unmask
    for (int v = 0; v < N; v++) begin
      reg_wr(0, v * 16 + 0, exp_addr(v)[31:0]);
      reg_wr(0, v * 16 + 4, exp_addr(v)[63:32]);
      reg_wr(0, v * 16 + 8, exp_data(v));
      reg_wr(0, v * 16 + 12, 32'd0);
    end
    reg_rd(0, 5 * 16 + 4, d);
    chk(d == exp_addr(5)[63:32], "R1", 64'(d), 64'(exp_addr(5)[63:32]));
    @(negedge clk); used = '1; en = 1; fmask = 0;

    // R4 each vector delivers its own message
    for (int v = 0; v < N; v++) begin
      irq(v);
      expect_msg(v, "R4");
    end

    // R5 unused and out-of-range requests dropped
    @(negedge clk); used[3] = 0;
    irq(3);
    expect_none("R5");
    irq(20);
    expect_none("R5");
    reg_rd(1, 0, d);
    chk(d == 0, "R5", 64'(d), 64'd0);
    @(negedge clk); used[3] = 1;

    // R6 masked request pends, R7 entry unmask replays
    reg_wr(0, 5 * 16 + 12, 32'd1);
    irq(5);
    expect_none("R6");
    reg_rd(1, 0, d);
    chk(d == 32'h20, "R6", 64'(d), 64'h20);
    reg_wr(0, 5 * 16 + 12, 32'd0);
    expect_msg(5, "R7");
    reg_rd(1, 0, d);
    chk(d == 0, "R7", 64'(d), 64'd0);

    // R3 enable low masks; R9 pending window writes ignored
    @(negedge clk); en = 0;
    irq(9);
    expect_none("R3");
    reg_wr(1, 0, 32'h0);
    reg_wr(1, 0, 32'hFFFF_FFFF);
    reg_wr(1, 4, 32'hFFFF_FFFF);
    reg_rd(1, 0, d);
    chk(d == 32'h200, "R9", 64'(d), 64'h200);
    reg_rd(1, 4, d);
    chk(d == 0, "R6", 64'(d), 64'd0);
    @(negedge clk); en = 1;
    expect_msg(9, "R7");

    // R8 function-mask release delivers all vectors in ascending order
    @(negedge clk); fmask = 1;
    for (int v = N - 1; v >= 0; v--) irq(v);
    reg_rd(1, 0, d);
    chk(d == 32'h0000_FFFF, "R3", 64'(d), 64'hFFFF);
    @(negedge clk); fmask = 0;
    for (int v = 0; v < N; v++) expect_msg(v, "R8");
    reg_rd(1, 0, d);
    chk(d == 0, "R7", 64'(d), 64'd0);

    // R10 clearing in-use drops pending
    reg_wr(0, 7 * 16 + 12, 32'd1);
    irq(7);
    reg_rd(1, 0, d);
    chk(d == 32'h80, "R10", 64'(d), 64'h80);
    @(negedge clk); used[7] = 0;
    reg_rd(1, 0, d);
    chk(d == 0, "R10", 64'(d), 64'd0);
    @(negedge clk); used[7] = 1;
    reg_wr(0, 7 * 16 + 12, 32'd0);
    expect_none("R10");

    // R11 message held until ready, unaffected by table writes
    @(negedge clk); mready = 0;
    irq(2);
    begin
      bit got; int gv; logic [63:0] ga; logic [31:0] gd;
      wait_msg(got, gv, ga, gd);
      chk(got && gv == 2, "R11", 64'(gv), 64'd2);
    end
    reg_wr(0, 2 * 16 + 8, 32'h0BAD_0BAD);
    reg_wr(0, 2 * 16 + 0, 32'h1234_5678);
    @(negedge clk);
    chk(mvalid && mdata == exp_data(2) && maddr == exp_addr(2), "R11",
        {maddr[31:0], mdata}, {exp_addr(2)[31:0], exp_data(2)});
    mready = 1;
    @(negedge clk);
    chk(!mvalid, "R11", 64'(mvalid), 64'd0);
    irq(2);
    begin
      bit got; int gv; logic [63:0] ga; logic [31:0] gd;
      wait_msg(got, gv, ga, gd);
      chk(got && gd == 32'h0BAD_0BAD, "R11", 64'(gd), 64'h0BAD_0BAD);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule